// File: doc/BRIEF.md
# Over-Temperature Alarm with Consecutive-Fault Filter

This block turns a stream of temperature results into a single alarm pin. Each time a new result arrives with a one-cycle strobe, the upper nine bits of the 11-bit two's-complement temperature are compared against two signed 9-bit limits: a trip limit and a release limit. A programmable count of consecutive qualifying results must be seen before the alarm changes state. This filters out isolated noisy samples.

The block has two operating styles. In thermostat style the alarm follows the temperature with hysteresis. Reads and shutdown do not affect it. In event style the alarm latches. It is cleared by any register-read pulse, or by the start of shutdown. The trips alternate between rising above the trip limit and falling below the release limit. The pin polarity is selectable.

The sample input has no back-pressure. Every strobe is taken in the cycle it is high, so the block has no ready output. A sample that arrives while shutdown is high is dropped. The configuration, read and shutdown pins are plain level or pulse controls.

Top module: `overtemp_alarm`

## Requirements
- R1: After reset the alarm is inactive; with `cfg_active_high`=0 the pin reads 1. After reset the filter count is zero and event style waits for a trip-limit crossing.
- R2: A result is evaluated only in a cycle with `sample_valid`=1 and `shutdown`=0. The evaluated value is `sample_temp[10:2]`, read as signed 9-bit; bits [1:0] have no effect.
- R3: In thermostat style (`cfg_event_mode`=0), an inactive alarm sets when the value is strictly greater than `limit_trip`, and an active alarm clears when the value is strictly less than `limit_release`. Any other value holds the state.
- R4: In thermostat style, `reg_read` pulses and shutdown leave the alarm unchanged.
- R5: In event style (`cfg_event_mode`=1), the first activation after reset or a style change needs a value strictly greater than `limit_trip`. The alarm then stays active until a cycle with `reg_read`=1, after which it is inactive. In that cycle a concurrent sample is not evaluated.
- R6: In event style, each clear switches the watched condition between "greater than `limit_trip`" and "less than `limit_release`". While the alarm is active, samples are ignored.
- R7: In event style, the first cycle of `shutdown`=1 (a rising edge) with the alarm active clears it, and this counts as a clear for R6.
- R8: `cfg_queue` values 0, 1, 2 and 3 require 1, 2, 4 and 6 consecutive qualifying evaluations. An evaluated sample that does not qualify resets the count. Reaching the count changes the alarm and restarts the count.
- R9: With `cfg_active_high`=1 the pin equals the alarm state; with 0 it is inverted. A polarity change appears on the pin in the same cycle.
- R10: A change of `cfg_event_mode` clears the alarm, zeroes the count and returns event style to waiting for a trip-limit crossing, all on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | One-cycle strobe: a new temperature result |
| sample_temp | input | 11 | Temperature, signed two's complement |
| limit_trip | input | 9 | Signed trip limit |
| limit_release | input | 9 | Signed release limit |
| cfg_event_mode | input | 1 | 0 thermostat style, 1 latched event style |
| cfg_active_high | input | 1 | Pin active level: 1 high, 0 low |
| cfg_queue | input | 2 | Consecutive-fault count code |
| reg_read | input | 1 | Pulse: a register read took place |
| shutdown | input | 1 | Converter is in shutdown |
| alarm_pin | output | 1 | Alarm output at the selected polarity |

## Verification
A corrupted fault count shows up as an alarm edge one or more samples early or late. This is visible only at the next evaluated sample, so the bench streams runs of qualifying values of every queue length. A wrong watched-condition state in event style makes the pin react to the wrong crossing right after a clear. A missed style-change reset leaves the pin active on the edge after the change. A behavioural model therefore compares the pin on every clock, so any divergence is caught within one cycle of becoming visible.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  typedef enum logic {WATCH_TRIP = 1'b0, WATCH_RELEASE = 1'b1} watch_e;

  localparam int QUEUE_MAX = 6;
  localparam int QCNT_W    = 3;

  function automatic logic [QCNT_W-1:0] queue_depth(input logic [1:0] code);
    case (code)
      2'd0:    return QCNT_W'(1);
      2'd1:    return QCNT_W'(2);
      2'd2:    return QCNT_W'(4);
      default: return QCNT_W'(6);
    endcase
  endfunction
endpackage

// File: rtl/limit_compare.sv
module limit_compare #(
  parameter int TEMP_W = 11,
  parameter int LIM_W  = 9
) (
  input  logic [TEMP_W-1:0] temp,
  input  logic [LIM_W-1:0]  lim_trip,
  input  logic [LIM_W-1:0]  lim_release,
  output logic              above_trip,
  output logic              below_release
);
  logic [LIM_W-1:0] coarse;

  always_comb begin
    coarse        = temp[TEMP_W-1 -: LIM_W];
    above_trip    = $signed(coarse) > $signed(lim_trip);
    below_release = $signed(coarse) < $signed(lim_release);
  end
endmodule

// File: rtl/fault_filter.sv
module fault_filter
  import alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       eval,
  input  logic       cond,
  input  logic [1:0] code,
  output logic       fire
);
  logic [QCNT_W-1:0] cnt_q;
  logic [QCNT_W:0]   next_cnt;
  logic [QCNT_W-1:0] need;

  always_comb begin
    need     = queue_depth(code);
    next_cnt = {1'b0, cnt_q} + 1'b1;
    fire     = eval && cond && (next_cnt >= {1'b0, need});
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear)            cnt_q <= '0;
    else if (eval) begin
      if (cond && !fire)       cnt_q <= next_cnt[QCNT_W-1:0];
      else                     cnt_q <= '0;
    end
  end

  // R8: the run length never reaches the largest queue depth
  a_r8_count_below_max: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < QCNT_W'(QUEUE_MAX));

  // R8: a non-qualifying evaluation restarts the run
  a_r8_miss_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !cond && !clear) |=> (cnt_q == '0));
endmodule

// File: rtl/overtemp_alarm.sv
module overtemp_alarm
  import alarm_pkg::*;
#(
  parameter int TEMP_W = 11,
  parameter int LIM_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [TEMP_W-1:0] sample_temp,
  input  logic [LIM_W-1:0]  limit_trip,
  input  logic [LIM_W-1:0]  limit_release,
  input  logic              cfg_event_mode,
  input  logic              cfg_active_high,
  input  logic [1:0]        cfg_queue,
  input  logic              reg_read,
  input  logic              shutdown,
  output logic              alarm_pin
);
  logic   mode_q, sd_q, alarm_q;
  watch_e watch_q;
  logic   above_trip, below_release;
  logic   mode_chg, sd_rise, evt_clear, eval, cond, fire;

  limit_compare #(.TEMP_W(TEMP_W), .LIM_W(LIM_W)) u_cmp (
    .temp          (sample_temp),
    .lim_trip      (limit_trip),
    .lim_release   (limit_release),
    .above_trip    (above_trip),
    .below_release (below_release)
  );

  always_comb begin
    mode_chg  = cfg_event_mode != mode_q;
    sd_rise   = shutdown && !sd_q;
    evt_clear = cfg_event_mode && !mode_chg && alarm_q && (reg_read || sd_rise);
    eval      = sample_valid && !shutdown && !mode_chg && !evt_clear
                && !(cfg_event_mode && alarm_q);
    if (cfg_event_mode) cond = (watch_q == WATCH_RELEASE) ? below_release : above_trip;
    else                cond = alarm_q ? below_release : above_trip;
  end

  fault_filter u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (mode_chg || evt_clear),
    .eval  (eval),
    .cond  (cond),
    .code  (cfg_queue),
    .fire  (fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      sd_q    <= 1'b0;
      alarm_q <= 1'b0;
      watch_q <= WATCH_TRIP;
    end else begin
      mode_q <= cfg_event_mode;
      sd_q   <= shutdown;
      if (mode_chg) begin
        alarm_q <= 1'b0;
        watch_q <= WATCH_TRIP;
      end else if (evt_clear) begin
        alarm_q <= 1'b0;
        watch_q <= (watch_q == WATCH_TRIP) ? WATCH_RELEASE : WATCH_TRIP;
      end else if (fire) begin
        alarm_q <= cfg_event_mode ? 1'b1 : !alarm_q;
      end
    end
  end

  assign alarm_pin = cfg_active_high ? alarm_q : !alarm_q;

  // R2: no activation without an evaluated sample
  a_r2_no_rise_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_q && !(sample_valid && !shutdown)) |=> !alarm_q);

  // R4: thermostat style only moves on evaluated samples
  a_r4_thermostat_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_event_mode && !mode_q && !(sample_valid && !shutdown)) |=> $stable(alarm_q));

  // R5: a read clears a latched event
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_event_mode && mode_q && alarm_q && reg_read) |=> !alarm_q);

  // R7: entering shutdown clears a latched event
  a_r7_shutdown_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_event_mode && mode_q && alarm_q && shutdown && !sd_q) |=> !alarm_q);

  // R10: a style change leaves the alarm inactive
  a_r10_mode_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_event_mode != mode_q) |=> !alarm_q);
endmodule

// File: tb/overtemp_alarm_test.sv
`timescale 1ns/1ps
module overtemp_alarm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b0;
  logic [10:0] sample_temp = '0;
  logic [8:0]  limit_trip = 9'd160;
  logic [8:0]  limit_release = 9'd150;
  logic        cfg_event_mode = 1'b0;
  logic        cfg_active_high = 1'b0;
  logic [1:0]  cfg_queue = 2'd0;
  logic        reg_read = 1'b0;
  logic        shutdown = 1'b0;
  logic        alarm_pin;

  always #2.5 clk = ~clk;

  overtemp_alarm uut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_temp(sample_temp),
    .limit_trip(limit_trip), .limit_release(limit_release),
    .cfg_event_mode(cfg_event_mode), .cfg_active_high(cfg_active_high),
    .cfg_queue(cfg_queue), .reg_read(reg_read), .shutdown(shutdown),
    .alarm_pin(alarm_pin)
  );

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";
  bit    done = 1'b0;
  int    cycles = 0;

  // behavioural reference
  bit m_alarm, m_watch_low, m_mode_q, m_sd_q;
  int m_run;

  function automatic int depth_of(input logic [1:0] c);
    int d[4] = '{1, 2, 4, 6};
    return d[c];
  endfunction

  always @(posedge clk) begin
    int  v, lo, hi;
    bit  qual, clr;
    if (!rst_n) begin
      m_alarm = 0; m_watch_low = 0; m_mode_q = 0; m_sd_q = 0; m_run = 0;
    end else begin
      v  = $signed(sample_temp[10:2]);
      hi = $signed(limit_trip);
      lo = $signed(limit_release);
      if (cfg_event_mode != m_mode_q) begin
        m_alarm = 0; m_watch_low = 0; m_run = 0;
      end else if (cfg_event_mode) begin
        clr = m_alarm && (reg_read || (shutdown && !m_sd_q));
        if (clr) begin
          m_alarm = 0; m_watch_low = !m_watch_low; m_run = 0;
        end else if (!m_alarm && sample_valid && !shutdown) begin
          qual = m_watch_low ? (v < lo) : (v > hi);
          if (qual) begin
            m_run++;
            if (m_run >= depth_of(cfg_queue)) begin m_alarm = 1; m_run = 0; end
          end else m_run = 0;
        end
      end else if (sample_valid && !shutdown) begin
        qual = m_alarm ? (v < lo) : (v > hi);
        if (qual) begin
          m_run++;
          if (m_run >= depth_of(cfg_queue)) begin m_alarm = !m_alarm; m_run = 0; end
        end else m_run = 0;
      end
      m_mode_q = cfg_event_mode;
      m_sd_q   = shutdown;
    end
  end

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: alarm_pin actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (rst_n && !done)
      check(alarm_pin, cfg_active_high ? m_alarm : !m_alarm, {cur_req, " model"});

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic smp(input int v, input int lsb = 0);
    sample_temp  = 11'((v * 4) + lsb);
    sample_valid = 1'b1;
    step();
    sample_valid = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    cur_req = "R1";
    check(alarm_pin, 1'b1, "R1 reset inactive, active-low pin");

    // thermostat style, depth 1
    cur_req = "R3";
    smp(165); check(alarm_pin, 1'b0, "R3 above trip sets");
    smp(155); check(alarm_pin, 1'b0, "R3 between holds");
    smp(150); check(alarm_pin, 1'b0, "R3 equal release holds");
    smp(149); check(alarm_pin, 1'b1, "R3 below release clears");

    cur_req = "R2";
    smp(160, 3); check(alarm_pin, 1'b1, "R2 low bits ignored at trip");
    sample_temp = 11'(200 * 4);
    repeat (3) step();
    check(alarm_pin, 1'b1, "R2 no strobe no compare");
    shutdown = 1'b1; smp(200); shutdown = 1'b0; step();
    check(alarm_pin, 1'b1, "R2 shutdown drops sample");
    smp(161); check(alarm_pin, 1'b0, "R2 just above trip");

    cur_req = "R4";
    reg_read = 1'b1; step(); reg_read = 1'b0;
    check(alarm_pin, 1'b0, "R4 read ignored");
    shutdown = 1'b1; step(); step(); shutdown = 1'b0; step();
    check(alarm_pin, 1'b0, "R4 shutdown ignored");
    smp(100); check(alarm_pin, 1'b1, "R4 clears after");

    cur_req = "R8";
    cfg_queue = 2'd2;
    repeat (3) smp(170);
    check(alarm_pin, 1'b1, "R8 three of four");
    smp(100);
    repeat (3) smp(170);
    check(alarm_pin, 1'b1, "R8 miss restarts run");
    smp(170); check(alarm_pin, 1'b0, "R8 fourth trips");
    repeat (3) smp(100);
    check(alarm_pin, 1'b0, "R8 release needs four");
    smp(100); check(alarm_pin, 1'b1, "R8 fourth release");
    cfg_queue = 2'd3;
    repeat (5) smp(170);
    check(alarm_pin, 1'b1, "R8 five of six");
    smp(170); check(alarm_pin, 1'b0, "R8 sixth trips");
    cfg_queue = 2'd0;
    smp(100); check(alarm_pin, 1'b1, "R8 depth one clears");

    cur_req = "R9";
    cfg_active_high = 1'b1; #1;
    check(alarm_pin, 1'b0, "R9 active high idle");
    smp(170); check(alarm_pin, 1'b1, "R9 active high set");
    cfg_active_high = 1'b0; #1;
    check(alarm_pin, 1'b0, "R9 back to active low");
    smp(100); check(alarm_pin, 1'b1, "R9 clear");

    cur_req = "R5";
    cfg_event_mode = 1'b1; step();
    check(alarm_pin, 1'b1, "R10 style change idle");
    smp(140); check(alarm_pin, 1'b1, "R5 first trip needs upper");
    smp(170); check(alarm_pin, 1'b0, "R5 upper trip latches");
    cur_req = "R6";
    smp(100); smp(170);
    check(alarm_pin, 1'b0, "R6 samples ignored while latched");
    cur_req = "R5";
    reg_read = 1'b1; step(); reg_read = 1'b0;
    check(alarm_pin, 1'b1, "R5 read clears");
    cur_req = "R6";
    smp(170); check(alarm_pin, 1'b1, "R6 upper ignored when watching release");
    smp(149); check(alarm_pin, 1'b0, "R6 release trip");
    reg_read = 1'b1; step(); reg_read = 1'b0;
    smp(149); check(alarm_pin, 1'b1, "R6 back to watching upper");
    smp(161); check(alarm_pin, 1'b0, "R6 upper again");

    cur_req = "R7";
    shutdown = 1'b1; step();
    check(alarm_pin, 1'b1, "R7 shutdown entry clears");
    step(); shutdown = 1'b0; step();
    smp(140); check(alarm_pin, 1'b0, "R7 clear advanced to release");

    cur_req = "R10";
    cfg_event_mode = 1'b0; step();
    check(alarm_pin, 1'b1, "R10 change clears alarm");
    smp(140); check(alarm_pin, 1'b1, "R10 thermostat restarts inactive");
    cfg_event_mode = 1'b1; step();
    smp(140); check(alarm_pin, 1'b1, "R10 event waits for upper");
    smp(170); check(alarm_pin, 1'b0, "R10 upper after change");
    cur_req = "R5";
    reg_read = 1'b1; smp(170); reg_read = 1'b0;
    check(alarm_pin, 1'b1, "R5 read wins over sample");
    cur_req = "R10";
    cfg_event_mode = 1'b0; step(); cfg_event_mode = 1'b1; step();
    cfg_queue = 2'd2;
    repeat (3) smp(170);
    cfg_event_mode = 1'b0; step(); cfg_event_mode = 1'b1; step();
    smp(170); check(alarm_pin, 1'b1, "R10 count zeroed");
    repeat (3) smp(170);
    check(alarm_pin, 1'b0, "R10 full run after restart");

    cur_req = "R2";
    cfg_event_mode = 1'b0; cfg_queue = 2'd0; step();
    limit_trip = 9'(-10); limit_release = 9'(-20);
    smp(-5);  check(alarm_pin, 1'b0, "R2 signed trip");
    smp(-25); check(alarm_pin, 1'b1, "R2 signed release");

    cur_req = "R8";
    limit_trip = 9'd160; limit_release = 9'd150;
    for (int i = 0; i < 3000; i++) begin
      sample_valid = ($urandom_range(0, 2) != 0);
      sample_temp  = 11'(($urandom_range(140, 170) * 4) + $urandom_range(0, 3));
      reg_read     = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 30) == 0) shutdown = !shutdown;
      if ($urandom_range(0, 150) == 0) cfg_event_mode = !cfg_event_mode;
      if ($urandom_range(0, 100) == 0) cfg_queue = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 200) == 0) cfg_active_high = !cfg_active_high;
      step();
    end
    sample_valid = 1'b0; reg_read = 1'b0;
    step();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule